// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a two-wire serial slave that gives a bus master byte-wide read and write access to an internal bank of 256 eight-bit registers. The master addresses the block with a fixed seven-bit device address. In a write, the first byte after the device address selects a register, and every following data byte is stored at the selected location. Reads return bytes starting at the current location. A single internal location counter steps after every byte moved in either direction, so one mechanism gives multibyte writes, current-location reads, random reads and sequential reads.

Both bus lines are sampled with the block's own system clock after a short synchronizer. Start and stop conditions and clock edges are detected from the sampled levels. The block never drives the data line high. Its single output is an open-drain pull-down enable, and the line seen by the master is the wired-AND of the master's drive and the inverted enable. Clock stretching and ten-bit addressing are not provided.

Top module: `i2c_reg_slave`

## Requirements
- R1: A falling data line while the clock is high (START) begins a new address phase from any state, including in the middle of a byte. A rising data line while the clock is high (STOP) returns the block to idle with the pull-down released.
- R2: The pull-down enable changes only while the sampled clock line is low.
- R3: The first byte after START is taken MSB first. If its upper seven bits equal 1000011, the block pulls the data line low during the ninth clock. Bit 0 selects the direction: 1 is read, 0 is write.
- R4: If the device address does not match, the block does not acknowledge and drives nothing for the rest of the transfer. Later bytes of that transfer change neither the registers nor the location counter, until the next START or STOP.
- R5: In a write, the byte after the device address loads the location counter. Each further byte is stored at the counter value, and the counter then advances by one. The block acknowledges both kinds of byte in the ninth clock.
- R6: A read that is not preceded by a sub-address returns, MSB first, the register at the current counter value. The counter then advances by one.
- R7: A repeated START after a sub-address byte, followed by a read address, returns the register selected by that sub-address.
- R8: While the master acknowledges each read byte, the block sends the next location. After a byte the master does not acknowledge, the block releases the data line until the next START or STOP.
- R9: The location counter wraps from 255 to 0 in both writes and reads.
- R10: After reset the pull-down is released, every register holds 0 and the location counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaOe | output | 1 | Pull-down enable for the data line, 1 drives it low |

## Verification
Directed transfers cover several cases: a current-location read straight after reset, a write that crosses location 255, a foreign address in both directions, a STOP in the middle of a byte, and a sequential read ended by a NACK followed by extra clocks. These separate ignore and release behaviour from ordinary acknowledge timing. Seeded random transfers mix multibyte writes at random sub-addresses, random reads through a repeated START, and bare current-location reads of random length. Every byte returned is compared against a bench model of the register bank and the shared counter. This shows that a single counter is shared between the two directions and steps once per byte. A line monitor flags any change of the pull-down while the master holds the clock high.

// File: rtl/i2c_slave_pkg.sv
package i2c_slave_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_SUB,
    ST_WR,
    ST_RD,
    ST_SKIP
  } busState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic shiftIn;   // take one sampled data bit into the receive register
    logic loadCnt;   // receive register -> location counter
    logic wrEn;      // receive register -> register bank at counter
    logic incCnt;    // counter + 1
    logic loadTx;    // register bank at counter -> transmit register
  } dpStrobe_t;

endpackage

// File: rtl/i2c_slave_sync.sv
module i2c_slave_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  // SYNC_STAGES must be at least 2
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[LAST-1:0], sclIn};
      sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
      sclPrev <= sclPipe[LAST];
      sdaPrev <= sdaPipe[LAST];
    end
  end

  assign sclLvl   = sclPipe[LAST];
  assign sdaLvl   = sdaPipe[LAST];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2c_slave_dp.sv
module i2c_slave_dp
  import i2c_slave_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaLvl,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] rxByte,
  output logic [DATA_W-1:0] txByte,
  output logic              memMsb
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regFile [DEPTH];
  logic [ADDR_W-1:0] addrCnt;
  logic [DATA_W-1:0] memRd;

  assign memRd  = regFile[addrCnt];
  assign memMsb = memRd[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txByte  <= '0;
      addrCnt <= '0;
    end else begin
      if (strobe.shiftIn) rxByte <= {rxByte[DATA_W-2:0], sdaLvl};
      if (strobe.loadTx)  txByte <= memRd;
      if (strobe.loadCnt)     addrCnt <= rxByte[ADDR_W-1:0];
      else if (strobe.incCnt) addrCnt <= addrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else if (strobe.wrEn) begin
      regFile[addrCnt] <= rxByte;
    end
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incCnt && !strobe.loadCnt) |=> addrCnt == ($past(addrCnt) + ADDR_W'(1))); // R9

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> regFile[$past(addrCnt)] == $past(rxByte)); // R5

  AST_SUB_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> addrCnt == $past(rxByte[ADDR_W-1:0])); // R5

endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_slave_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-2:0] DEV_ADDR = 7'b1000011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclLvl,
  input  logic              sdaLvl,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] txByte,
  input  logic              memMsb,
  output dpStrobe_t         strobe,
  output logic              sdaOe
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(DATA_W + 1);

  busState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic            isRead;
  logic            mstNack;
  logic            addrMatch;
  logic            atByteEnd;
  logic            atAckEnd;
  logic            txBit;

  assign addrMatch = (rxByte[DATA_W-1:1] == DEV_ADDR);
  assign atByteEnd = sclFall && (bitCnt == BYTE_END);
  assign atAckEnd  = sclFall && (bitCnt == ACK_END);

  // next transmit bit, MSB first, chosen by bits already clocked
  always_comb begin
    txBit = 1'b1;
    for (int i = 0; i < DATA_W; i++)
      if (bitCnt == CNT_W'(DATA_W - 1 - i)) txBit = txByte[i];
  end

  always_comb begin
    strobe.shiftIn = sclRise && (bitCnt < BYTE_END) &&
                     (state == ST_DEV || state == ST_SUB || state == ST_WR);
    strobe.loadCnt = atByteEnd && (state == ST_SUB);
    strobe.wrEn    = atByteEnd && (state == ST_WR);
    strobe.incCnt  = atByteEnd && (state == ST_WR || state == ST_RD);
    strobe.loadTx  = atAckEnd && ((state == ST_DEV && isRead) ||
                                  (state == ST_RD && !mstNack));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      mstNack <= 1'b1;
      sdaOe   <= 1'b0;
    end else if (startDet) begin
      state  <= ST_DEV;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (sclRise) begin
      if (state != ST_IDLE && state != ST_SKIP) bitCnt <= bitCnt + 1'b1;
      if (state == ST_RD && bitCnt == BYTE_END) mstNack <= sdaLvl;
    end else if (atByteEnd) begin
      unique case (state)
        ST_DEV: begin
          if (addrMatch) begin
            sdaOe  <= 1'b1;
            isRead <= rxByte[0];
          end else begin
            state <= ST_SKIP;
            sdaOe <= 1'b0;
          end
        end
        ST_SUB, ST_WR: sdaOe <= 1'b1;
        ST_RD:         sdaOe <= 1'b0;
        default:       sdaOe <= 1'b0;
      endcase
    end else if (atAckEnd) begin
      bitCnt <= '0;
      unique case (state)
        ST_DEV: begin
          state <= isRead ? ST_RD : ST_SUB;
          sdaOe <= isRead ? ~memMsb : 1'b0;
        end
        ST_SUB: begin
          state <= ST_WR;
          sdaOe <= 1'b0;
        end
        ST_RD: begin
          if (mstNack) begin
            state <= ST_SKIP;
            sdaOe <= 1'b0;
          end else begin
            sdaOe <= ~memMsb;
          end
        end
        default: sdaOe <= 1'b0;
      endcase
    end else if (sclFall && state == ST_RD && bitCnt != '0 && bitCnt < BYTE_END) begin
      sdaOe <= ~txBit;
    end
  end

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> (!sclLvl || $past(startDet || stopDet))); // R2

  AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEV && atByteEnd && !startDet && !stopDet && rxByte[DATA_W-1:1] == DEV_ADDR)
    |=> sdaOe); // R3

  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaOe); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadCnt, strobe.wrEn, strobe.loadTx})); // R5

  AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == ST_IDLE && !sdaOe)); // R1

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slave_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-2:0] DEV_ADDR    = 7'b1000011
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  logic sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic [DATA_W-1:0] rxByte;
  logic [DATA_W-1:0] txByte;
  logic memMsb;
  dpStrobe_t strobe;

  i2c_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_slave_ctrl #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaLvl(sdaLvl),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rxByte(rxByte), .txByte(txByte), .memMsb(memMsb),
    .strobe(strobe), .sdaOe(sdaOe)
  );

  i2c_slave_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .strobe(strobe),
    .rxByte(rxByte), .txByte(txByte), .memMsb(memMsb)
  );

endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;

  localparam int Q = 8;               // clocks per quarter bit
  localparam logic [7:0] WR_ADDR = 8'h86;
  localparam logic [7:0] RD_ADDR = 8'h87;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic done = 1'b0;

  int checks = 0;
  int failures = 0;
  int r2Bad = 0;

  logic [7:0] refMem [256];
  int refCnt = 0;

  always #2 clk = ~clk;   // 250 MHz

  assign sdaLine = sdaDrv & ~sdaOe;

  i2c_reg_slave i_i2c_reg_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe)
  );

  // R2 line monitor: pull-down may move only while the master holds SCL low
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && sdaOe != prevOe && sclDrv) r2Bad++;
    prevOe <= sdaOe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    sdaDrv = b;
    waitClk(Q);
    sclDrv = 1'b1;
    waitClk(Q);
    seen = sdaLine;
    waitClk(Q);
    sclDrv = 1'b0;
    waitClk(Q);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1;
    waitClk(Q);
    sclDrv = 1'b1;
    waitClk(Q);
    sdaDrv = 1'b0;
    waitClk(Q);
    sclDrv = 1'b0;
    waitClk(Q);
  endtask

  task automatic busStop();
    sdaDrv = 1'b0;
    waitClk(Q);
    sclDrv = 1'b1;
    waitClk(Q);
    sdaDrv = 1'b1;
    waitClk(Q);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      d[i] = s;
    end
    clockBit(!giveAck, s);
  endtask

  // multibyte write from a sub-address, model updated alongside
  task automatic doWrite(input logic [7:0] sub, input int n);
    logic a;
    logic [7:0] d;
    busStart();
    writeByte(WR_ADDR, a);
    chk("R3 write address ack", int'(a), 1);
    writeByte(sub, a);
    chk("R5 sub-address ack", int'(a), 1);
    refCnt = int'(sub);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      writeByte(d, a);
      chk("R5 data ack", int'(a), 1);
      refMem[refCnt] = d;
      refCnt = (refCnt + 1) % 256;
    end
    busStop();
  endtask

  // read of n bytes; withSub selects a random read through repeated START
  task automatic doRead(input logic withSub, input logic [7:0] sub, input int n, input string req);
    logic a;
    logic [7:0] d;
    busStart();
    if (withSub) begin
      writeByte(WR_ADDR, a);
      chk("R7 address ack", int'(a), 1);
      writeByte(sub, a);
      chk("R7 sub-address ack", int'(a), 1);
      refCnt = int'(sub);
      busStart();
    end
    writeByte(RD_ADDR, a);
    chk("R3 read address ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      readByte(k != n - 1, d);
      chk(req, int'(d), int'(refMem[refCnt]));
      refCnt = (refCnt + 1) % 256;
    end
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    void'($urandom(32'h5EED_0C2A));
    for (int i = 0; i < 256; i++) refMem[i] = 8'h00;
    waitClk(5);
    chk("R10 pull-down released in reset", int'(sdaOe), 0);
    rstN = 1'b1;
    waitClk(5);
    chk("R10 pull-down released after reset", int'(sdaOe), 0);

    // R10 / R6: bare read after reset starts at location 0 holding zeros
    doRead(1'b0, 8'h00, 3, "R6 current read after reset");

    // R9: write across the top of the bank, read back across it
    doWrite(8'hFE, 4);
    doRead(1'b1, 8'hFE, 4, "R9 wrap read");
    // counter now at 2: bare read continues from there
    doRead(1'b0, 8'h00, 2, "R6 current read continues");

    // R4: foreign address, write direction
    busStart();
    writeByte(8'h88, a);
    chk("R4 no ack on foreign address", int'(a), 0);
    writeByte(8'h10, a);
    chk("R4 no ack on ignored sub", int'(a), 0);
    writeByte(8'h5A, a);
    chk("R4 no ack on ignored data", int'(a), 0);
    busStop();
    doRead(1'b0, 8'h00, 1, "R4 counter and bank untouched");

    // R4: foreign address, read direction: line stays released
    busStart();
    writeByte(8'hC7, a);
    chk("R4 no ack on foreign read address", int'(a), 0);
    readByte(1'b0, d);
    chk("R4 nothing driven on foreign read", int'(d), 8'hFF);
    busStop();

    // R1: STOP in the middle of a byte, then a normal transfer
    busStart();
    writeByte(WR_ADDR, a);
    chk("R1 ack before abort", int'(a), 1);
    for (int i = 0; i < 3; i++) clockBit(1'b0, a);
    busStop();
    waitClk(4);
    chk("R1 released after STOP", int'(sdaOe), 0);
    doWrite(8'h40, 3);
    doRead(1'b1, 8'h40, 3, "R1 transfer after abort");

    // R8: NACK ends the output, extra clocks see a released line
    doWrite(8'h80, 2);
    busStart();
    writeByte(WR_ADDR, a);
    writeByte(8'h80, a);
    busStart();
    writeByte(RD_ADDR, a);
    readByte(1'b1, d);
    chk("R8 first byte", int'(d), int'(refMem[8'h80]));
    readByte(1'b0, d);
    chk("R8 second byte", int'(d), int'(refMem[8'h81]));
    readByte(1'b0, d);
    chk("R8 released after NACK", int'(d), 8'hFF);
    busStop();
    refCnt = 8'h82;

    // seeded random mix
    for (int t = 0; t < 28; t++) begin
      int kind;
      kind = int'($urandom % 3);
      if (kind == 0) doWrite(8'($urandom), 1 + int'($urandom % 6));
      else if (kind == 1) doRead(1'b1, 8'($urandom), 1 + int'($urandom % 5), "R7 random read");
      else doRead(1'b0, 8'h00, 1 + int'($urandom % 4), "R6 current read");
    end

    chk("R2 pull-down stable while SCL high", r2Bad, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule